// File: doc/BRIEF.md
# Per-Vector Interrupt Cause and Mask Array

This block holds one byte-wide control register per message-signalled interrupt vector and decides when each vector may fire. Internal event sources raise requests on a vector for one of two reasons: ring (receive or transmit) activity, or a change of link state. A vector whose register reads zero is open. When a request reaches an open vector, the block pulses that vector's message request for one cycle and writes the cause code into its register. The non-zero cause then keeps the vector closed until host software writes zero back.

Requests that reach a closed vector are remembered as pending flags, one per cause. They fire as soon as the host reopens the vector. An automatic-masking mode bit bypasses the registers completely: in that mode every request goes straight to a message pulse and the registers stay as they are. The host reads and writes the registers through a simple byte port, where vector N sits at address N.

Top module: `irq_cause_array`

## Requirements
- R1: Reset clears every register to zero, removes every pending request and holds all message pulses low. A request that was pending before reset does not fire after reset.
- R2: With automatic masking off, a request on a vector whose register is zero produces a one-cycle pulse on that vector's `msi_fire` bit after the next clock edge. At the same edge the register takes cause code 1 for ring activity or cause code 2 for a link change.
- R3: A request on a vector whose register is non-zero produces no pulse and is held pending. The pending request fires on the edge after the host's write of zero takes effect.
- R4: When ring and link requests meet on one vector in the same firing decision, whether new or pending, only one pulse is produced and the stored cause is 2 (link change wins).
- R5: With `auto_mask` high, every request or pending request pulses its vector at the next edge whatever the register holds. Requests then leave the registers unchanged.
- R6: A host write stores `host_wdata` into the register at `host_waddr` at the clock edge, and `host_rdata` returns the register at `host_raddr` combinationally. A host-written non-zero value closes the vector just as a stored cause does.
- R7: If a vector fires in the same cycle that the host writes that vector, the stored cause is kept and the host write is discarded.
- R8: Several requests that arrive while a vector is closed produce exactly one pulse once it reopens. Pending requests are flags, not counts.
- R9: Vectors act independently: a request, pulse or host write on one vector does not change another vector's register, pending state or pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mask | input | 1 | Automatic masking mode; registers bypassed when high |
| ring_req | input | NUM_VEC | Per-vector ring activity request |
| link_req | input | NUM_VEC | Per-vector link state change request |
| host_we | input | 1 | Host write strobe |
| host_waddr | input | AW | Host write vector index |
| host_wdata | input | 8 | Host write data |
| host_raddr | input | AW | Host read vector index |
| host_rdata | output | 8 | Register contents at `host_raddr` |
| msi_fire | output | NUM_VEC | One-cycle message request per vector |

## Verification
The hardest situations to reach from the ports are the collisions. One is a request held pending on a closed vector that must fire exactly once, on the edge after the host's zero write lands. The other is a host write that hits a vector in the very cycle it fires. The stimulus closes vectors, piles up ring and link requests on them, and then times the host's zero write against them cycle by cycle. It also drives a request and a host write to the same open vector on a single edge. A closing scenario arms a pending request and then resets the block, so the bench can show that the request does not survive.

// File: rtl/irq_cause_pkg.sv
`timescale 1ns/1ps
package irq_cause_pkg;
  localparam int CAUSE_W = 8;
  typedef logic [CAUSE_W-1:0] cause_t;

  localparam cause_t CAUSE_OPEN = cause_t'(0);
  localparam cause_t CAUSE_RING = cause_t'(1);
  localparam cause_t CAUSE_LINK = cause_t'(2);

  // Link change outranks ring activity for the stored cause.
  function automatic cause_t pick_cause(input logic want_ring, input logic want_link);
    if (want_link)      return CAUSE_LINK;
    else if (want_ring) return CAUSE_RING;
    else                return CAUSE_OPEN;
  endfunction

  function automatic logic is_open(input cause_t c);
    return (c == CAUSE_OPEN);
  endfunction
endpackage

// File: rtl/irq_wr_decode.sv
`timescale 1ns/1ps
module irq_wr_decode #(
  parameter int NUM_VEC = 8,
  parameter int AW      = 3
) (
  input  logic               we,
  input  logic [AW-1:0]      addr,
  output logic [NUM_VEC-1:0] sel
);
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_sel
    assign sel[g] = we && (int'(addr) == g);
  end
endmodule

// File: rtl/irq_rd_mux.sv
`timescale 1ns/1ps
module irq_rd_mux
  import irq_cause_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int AW      = 3
) (
  input  cause_t [NUM_VEC-1:0] regs,
  input  logic   [AW-1:0]      addr,
  output cause_t               data
);
  always_comb begin
    data = CAUSE_OPEN;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (int'(addr) == i) data = regs[i];
    end
  end
endmodule

// File: rtl/irq_vec_slot.sv
`timescale 1ns/1ps
module irq_vec_slot
  import irq_cause_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   auto_mask,
  input  logic   ring_req,
  input  logic   link_req,
  input  logic   host_wr,
  input  cause_t host_wdata,
  output cause_t cause_q,
  output logic   fire_q,
  output logic   pend_q
);
  logic pend_ring_q, pend_link_q;
  logic want_ring, want_link, want_any;
  logic take, store;

  assign want_ring = ring_req | pend_ring_q;
  assign want_link = link_req | pend_link_q;
  assign want_any  = want_ring | want_link;
  assign take      = want_any && (auto_mask || is_open(cause_q));
  assign store     = take && !auto_mask;
  assign pend_q    = pend_ring_q | pend_link_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q     <= CAUSE_OPEN;
      fire_q      <= 1'b0;
      pend_ring_q <= 1'b0;
      pend_link_q <= 1'b0;
    end else begin
      fire_q <= take;
      if (take) begin
        pend_ring_q <= 1'b0;
        pend_link_q <= 1'b0;
      end else begin
        pend_ring_q <= want_ring;
        pend_link_q <= want_link;
      end
      if (store)        cause_q <= pick_cause(want_ring, want_link);
      else if (host_wr) cause_q <= host_wdata;
    end
  end
endmodule

// File: rtl/irq_cause_array.sv
`timescale 1ns/1ps
module irq_cause_array
  import irq_cause_pkg::*;
#(
  parameter int NUM_VEC = 8,
  localparam int AW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               auto_mask,
  input  logic [NUM_VEC-1:0] ring_req,
  input  logic [NUM_VEC-1:0] link_req,
  input  logic               host_we,
  input  logic [AW-1:0]      host_waddr,
  input  logic [7:0]         host_wdata,
  input  logic [AW-1:0]      host_raddr,
  output logic [7:0]         host_rdata,
  output logic [NUM_VEC-1:0] msi_fire
);
  // Named internal wires brought out for the bound checker.
  cause_t [NUM_VEC-1:0] cause_regs;
  logic   [NUM_VEC-1:0] wr_sel;
  logic   [NUM_VEC-1:0] pend_vec;
  cause_t               rd_word;

  irq_wr_decode #(.NUM_VEC(NUM_VEC), .AW(AW)) u_dec (
    .we  (host_we),
    .addr(host_waddr),
    .sel (wr_sel)
  );

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_slot
    irq_vec_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .auto_mask (auto_mask),
      .ring_req  (ring_req[v]),
      .link_req  (link_req[v]),
      .host_wr   (wr_sel[v]),
      .host_wdata(cause_t'(host_wdata)),
      .cause_q   (cause_regs[v]),
      .fire_q    (msi_fire[v]),
      .pend_q    (pend_vec[v])
    );
  end

  irq_rd_mux #(.NUM_VEC(NUM_VEC), .AW(AW)) u_rd (
    .regs(cause_regs),
    .addr(host_raddr),
    .data(rd_word)
  );

  assign host_rdata = 8'(rd_word);
endmodule

// File: rtl/irq_cause_array_chk.sv
`timescale 1ns/1ps
module irq_cause_array_chk
  import irq_cause_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 auto_mask,
  input cause_t [NUM_VEC-1:0] cause_regs,
  input logic   [NUM_VEC-1:0] wr_sel,
  input logic   [NUM_VEC-1:0] pend_vec,
  input logic   [NUM_VEC-1:0] msi_fire
);
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_chk
    p_fire_when_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (msi_fire[v] && !$past(auto_mask)) |-> ($past(cause_regs[v]) == CAUSE_OPEN));

    p_fire_stores_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (msi_fire[v] && !$past(auto_mask)) |->
        (cause_regs[v] == CAUSE_RING || cause_regs[v] == CAUSE_LINK));

    p_closed_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(auto_mask) && $past(cause_regs[v]) != CAUSE_OPEN) |-> !msi_fire[v]);

    p_pending_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pend_vec[v] && (auto_mask || cause_regs[v] == CAUSE_OPEN)) |-> msi_fire[v]);

    p_auto_regs_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(auto_mask) && !$past(wr_sel[v])) |-> $stable(cause_regs[v]));
  end
endmodule

bind irq_cause_array irq_cause_array_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .auto_mask (auto_mask),
  .cause_regs(cause_regs),
  .wr_sel    (wr_sel),
  .pend_vec  (pend_vec),
  .msi_fire  (msi_fire)
);

// File: tb/irq_cause_array_tb.sv
`timescale 1ns/1ps
module irq_cause_array_tb;
  localparam int NV = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          auto_mask = 1'b0;
  logic [NV-1:0] ring_req = '0;
  logic [NV-1:0] link_req = '0;
  logic          host_we = 1'b0;
  logic [AW-1:0] host_waddr = '0;
  logic [7:0]    host_wdata = '0;
  logic [AW-1:0] host_raddr = '0;
  logic [7:0]    host_rdata;
  logic [NV-1:0] msi_fire;

  always #4 clk = ~clk;

  irq_cause_array #(.NUM_VEC(NV)) u_dut (
    .clk(clk), .rst_n(rst_n), .auto_mask(auto_mask),
    .ring_req(ring_req), .link_req(link_req),
    .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata), .msi_fire(msi_fire)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // Behavioural reference state.
  int m_reg  [NV];
  bit m_pr   [NV];
  bit m_pl   [NV];
  bit m_fire [NV];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int v = 0; v < NV; v++) begin
      m_reg[v] = 0; m_pr[v] = 0; m_pl[v] = 0; m_fire[v] = 0;
    end
  endtask

  task automatic model_edge();
    for (int v = 0; v < NV; v++) begin
      bit r, l, wr;
      r  = ring_req[v] | m_pr[v];
      l  = link_req[v] | m_pl[v];
      wr = host_we && (int'(host_waddr) == v);
      m_fire[v] = 0;
      if ((r || l) && (auto_mask || m_reg[v] == 0)) begin
        m_fire[v] = 1;
        m_pr[v] = 0; m_pl[v] = 0;
        if (!auto_mask) m_reg[v] = l ? 2 : 1;
        else if (wr)    m_reg[v] = host_wdata;
      end else begin
        m_pr[v] = r; m_pl[v] = l;
        if (wr) m_reg[v] = host_wdata;
      end
    end
  endtask

  task automatic compare(input string tag);
    for (int v = 0; v < NV; v++) begin
      chk(tag, $sformatf("fire[%0d]", v), int'(msi_fire[v]), int'(m_fire[v]));
      host_raddr = AW'(v);
      #0.1;
      chk(tag, $sformatf("reg[%0d]", v), int'(host_rdata), m_reg[v]);
    end
  endtask

  // Inputs are driven in the low phase; model advances at the edge; compare at the next negedge.
  task automatic step(input string tag, input logic [NV-1:0] rr, input logic [NV-1:0] lr,
                      input bit we, input int wa, input int wd);
    ring_req = rr; link_req = lr;
    host_we = we; host_waddr = AW'(wa); host_wdata = 8'(wd);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    ring_req = '0; link_req = '0; host_we = 1'b0;
    compare(tag);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, '0, '0, 0, 0, 0);
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    compare("R1 reset state");
    rst_n = 1'b1;
    idle("R1 idle after reset", 2);

    // R2: open vectors fire and record cause.
    step("R2 ring on v0", 8'h01, 8'h00, 0, 0, 0);
    step("R2 link on v3", 8'h00, 8'h08, 0, 0, 0);
    idle("R2 single pulse", 1);

    // R3/R8: closed vector collects requests; one pulse after zero write.
    step("R3 ring on closed v0", 8'h01, 8'h00, 0, 0, 0);
    step("R8 second ring on closed v0", 8'h01, 8'h00, 0, 0, 0);
    step("R4 link joins pending on v0", 8'h00, 8'h01, 0, 0, 0);
    step("R3 host reopens v0", 8'h00, 8'h00, 1, 0, 0);
    step("R3 pending fires on v0", 8'h00, 8'h00, 0, 0, 0);
    idle("R8 no second pulse", 2);

    // R4: simultaneous ring and link on open v5.
    step("R4 ring+link on v5", 8'h20, 8'h20, 0, 0, 0);
    idle("R4 one pulse", 1);

    // R6: host masks v6 with arbitrary value.
    step("R6 host writes 0x5A to v6", 8'h00, 8'h00, 1, 6, 8'h5A);
    step("R6 link on host-closed v6", 8'h00, 8'h40, 0, 0, 0);
    step("R6 host reopens v6", 8'h00, 8'h00, 1, 6, 0);
    step("R6 v6 pending fires", 8'h00, 8'h00, 0, 0, 0);

    // R7: fire and host write collide on v1.
    step("R7 ring and write 0x33 on v1", 8'h02, 8'h00, 1, 1, 8'h33);
    idle("R7 settle", 1);

    // R5: automatic masking bypasses registers.
    auto_mask = 1'b1;
    step("R5 ring on closed v3 in auto", 8'h08, 8'h00, 0, 0, 0);
    step("R5 link on open v2 in auto", 8'h00, 8'h04, 0, 0, 0);
    step("R5 repeated request in auto", 8'h08, 8'h04, 0, 0, 0);
    step("R5 host write in auto", 8'h00, 8'h00, 1, 2, 8'h07);
    auto_mask = 1'b0;
    idle("R5 back to normal", 1);

    // R9: several vectors at once, open and closed.
    step("R9 clear v3", 8'h00, 8'h00, 1, 3, 0);
    step("R9 mixed vectors", 8'h8A, 8'h10, 0, 0, 0);
    step("R9 write v4 while v7 active", 8'h80, 8'h00, 1, 4, 0);
    idle("R9 settle", 2);

    // R1: pending request does not survive reset.
    step("R1 close v7", 8'h00, 8'h00, 1, 7, 1);
    step("R1 ring on closed v7", 8'h80, 8'h00, 0, 0, 0);
    rst_n = 1'b0;
    model_clear();
    #1;
    compare("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1 pending dropped", 3);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule